// File: doc/BRIEF.md
# Quad Wiper Register I2C Target

This block is the digital front end of a four-channel digitally controlled potentiometer. It is an I2C target that holds four volatile wiper registers and presents their values as a packed output bus. That bus drives the analog tap selectors. A system clock samples SCL and SDA through synchronizers, and the block answers on SDA through an open-drain pull-down enable. Three static select pins set its bus identity, so up to eight such targets can share one bus.

A controller writes a register by sending, in order:

1. the identification byte with the read/write bit clear,
2. a register address,
3. one or more data bytes.

Each data byte goes into its register on the acknowledge clock of that byte, without waiting for STOP. Further data bytes go to the following channels, wrapping from 3 back to 0.

To read, the controller sends the identification byte with the read/write bit clear, then the address byte, then a repeated START, then the identification byte with the read/write bit set. The target then streams register contents from the addressed channel onward until the controller sends a NACK.

Top module: `quad_wiper_i2c_target`

## Requirements
- R1: After reset every wiper output is 128 (0x80) and the SDA pull-down enable is low.
- R2: The first byte after a START or repeated START is accepted only when its bits 7..4 are 1010 and its bits 3..1 equal `addr_sel[2:1:0]` in that order. Bit 0 is the read/write flag, with 1 meaning read. A mismatching byte is not acknowledged, and the rest of that transaction changes no wiper.
- R3: An address byte of 0 to 3 selects wiper 0 to 3 and is acknowledged. Any other address value is not acknowledged, and no wiper changes in that transaction.
- R4: Each acknowledged data byte is copied into the selected wiper during its ninth SCL clock, before any STOP.
- R5: Each further data byte in the same write goes to the next channel, wrapping from 3 to 0. At most one wiper changes at a time.
- R6: After address, repeated START and a read identification byte, the target sends the addressed wiper MSB first. Each byte the controller acknowledges is followed by the next channel's value, wrapping from 3 to 0.
- R7: After the controller NACKs a read byte, the target releases SDA, and SDA is released at every STOP.
- R8: The target changes its SDA drive only while SCL is low, so data it sends is stable throughout each SCL high phase.
- R9: A START or STOP inside a byte abandons that byte without writing any wiper. The next START is decoded as a new identification byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | When high, the target pulls SDA low |
| addr_sel | input | 3 | Static select pins compared with identification bits 3..1 |
| wipers | output | NCH*WIPER_W (32) | Packed wiper values; channel i occupies bits i*WIPER_W +: WIPER_W |

## Verification
A wrong register pointer shows up on the wiper bus at the ninth clock of the next data byte: the wrong channel moves. In a read it shows up at the first byte returned after the repeated START. A wrong decode of the identification or address byte shows up at once as a wrong acknowledge level on SDA during that byte's ninth clock. A state machine that fails to return to idle shows up as SDA held low after a NACK or STOP. Writes that are cut short by a START or STOP are checked on the wiper outputs straight after the STOP.

// File: rtl/qw_pkg.sv
package qw_pkg;
   localparam int BYTE_BITS = 8;
   localparam logic [3:0] ID_PREFIX = 4'b1010;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RX,
      ST_ACK,
      ST_TX,
      ST_TXACK,
      ST_TXLOAD,
      ST_SKIP
   } qw_state_t;

   typedef enum logic [1:0] {
      BK_ID,
      BK_ADDR,
      BK_DATA
   } qw_kind_t;
endpackage

// File: rtl/qw_line_sync.sv
module qw_line_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   logic [STAGES-1:0] scl_pipe;
   logic [STAGES-1:0] sda_pipe;
   logic              scl_p;
   logic              sda_p;
   logic              scl_s;

   if (STAGES < 2) begin : g_bad_stages
      $error("qw_line_sync needs at least two synchronizer stages");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_pipe <= '1;
         sda_pipe <= '1;
         scl_p    <= 1'b1;
         sda_p    <= 1'b1;
      end else begin
         scl_pipe <= {scl_pipe[STAGES-2:0], scl_i};
         sda_pipe <= {sda_pipe[STAGES-2:0], sda_i};
         scl_p    <= scl_pipe[STAGES-1];
         sda_p    <= sda_pipe[STAGES-1];
      end
   end

   assign scl_s     = scl_pipe[STAGES-1];
   assign sda_s     = sda_pipe[STAGES-1];
   assign scl_rise  = scl_s & ~scl_p;
   assign scl_fall  = ~scl_s & scl_p;
   assign start_det = scl_s & scl_p & sda_p & ~sda_s;
   assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;
endmodule

// File: rtl/qw_wiper_bank.sv
module qw_wiper_bank #(
   parameter int NCH       = 4,
   parameter int WW        = 8,
   parameter int RESET_VAL = 128,
   localparam int PW       = (NCH > 1) ? $clog2(NCH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [PW-1:0]     idx,
   input  logic [WW-1:0]     wr_data,
   output logic [WW-1:0]     rd_data,
   output logic [NCH*WW-1:0] wipers
);
   logic [WW-1:0] regs [NCH];

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            regs[i] <= WW'(RESET_VAL);
         end else if (wr_en && (idx == PW'(i))) begin
            regs[i] <= wr_data;
         end
      end
      assign wipers[i*WW +: WW] = regs[i];
   end

   always_comb begin
      rd_data = '0;
      for (int k = 0; k < NCH; k++) begin
         if (idx == PW'(k)) rd_data = regs[k];
      end
   end
endmodule

// File: rtl/qw_proto.sv
module qw_proto
   import qw_pkg::*;
#(
   parameter int NCH = 4,
   parameter int WW  = 8,
   localparam int PW = (NCH > 1) ? $clog2(NCH) : 1,
   localparam int CW = $clog2(BYTE_BITS + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          sda_s,
   input  logic          scl_rise,
   input  logic          scl_fall,
   input  logic          start_det,
   input  logic          stop_det,
   input  logic [2:0]    addr_sel,
   input  logic [WW-1:0] rd_data,
   output logic          wr_en,
   output logic [PW-1:0] ptr,
   output logic [WW-1:0] wr_data,
   output logic          sda_oe
);
   qw_state_t            state;
   qw_kind_t             kind;
   logic [CW-1:0]        cnt;
   logic [BYTE_BITS-1:0] rx_sh;
   logic [BYTE_BITS-1:0] tx_sh;
   logic                 rw_q;
   logic                 id_hit;
   logic                 addr_ok;
   logic [PW-1:0]        ptr_nxt;
   logic [BYTE_BITS-1:0] rd_byte;
   logic                 byte_done;

   assign id_hit    = (rx_sh[7:4] == ID_PREFIX) && (rx_sh[3:1] == addr_sel);
   assign addr_ok   = {1'b0, rx_sh} < 9'(NCH);
   assign ptr_nxt   = (ptr == PW'(NCH - 1)) ? '0 : ptr + 1'b1;
   assign rd_byte   = BYTE_BITS'(rd_data);
   assign byte_done = (cnt == CW'(BYTE_BITS));
   assign wr_data   = rx_sh[WW-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         kind   <= BK_ID;
         cnt    <= '0;
         rx_sh  <= '0;
         tx_sh  <= '0;
         rw_q   <= 1'b0;
         ptr    <= '0;
         sda_oe <= 1'b0;
         wr_en  <= 1'b0;
      end else begin
         wr_en <= 1'b0;
         if (stop_det) begin
            state  <= ST_IDLE;
            sda_oe <= 1'b0;
         end else if (start_det) begin
            state  <= ST_RX;
            kind   <= BK_ID;
            cnt    <= '0;
            sda_oe <= 1'b0;
         end else begin
            case (state)
               ST_RX: begin
                  if (scl_rise && !byte_done) begin
                     rx_sh <= {rx_sh[BYTE_BITS-2:0], sda_s};
                     cnt   <= cnt + 1'b1;
                  end else if (scl_fall && byte_done) begin
                     case (kind)
                        BK_ID: begin
                           if (id_hit) begin
                              rw_q   <= rx_sh[0];
                              sda_oe <= 1'b1;
                              state  <= ST_ACK;
                           end else begin
                              state <= ST_SKIP;
                           end
                        end
                        BK_ADDR: begin
                           if (addr_ok) begin
                              ptr    <= rx_sh[PW-1:0];
                              sda_oe <= 1'b1;
                              state  <= ST_ACK;
                           end else begin
                              state <= ST_SKIP;
                           end
                        end
                        default: begin
                           sda_oe <= 1'b1;
                           state  <= ST_ACK;
                        end
                     endcase
                  end
               end
               ST_ACK: begin
                  if (scl_rise && kind == BK_DATA) begin
                     wr_en <= 1'b1;
                  end else if (scl_fall) begin
                     cnt <= '0;
                     case (kind)
                        BK_ID: begin
                           if (rw_q) begin
                              tx_sh  <= rd_byte;
                              sda_oe <= ~rd_byte[BYTE_BITS-1];
                              state  <= ST_TX;
                           end else begin
                              sda_oe <= 1'b0;
                              kind   <= BK_ADDR;
                              state  <= ST_RX;
                           end
                        end
                        BK_ADDR: begin
                           sda_oe <= 1'b0;
                           kind   <= BK_DATA;
                           state  <= ST_RX;
                        end
                        default: begin
                           sda_oe <= 1'b0;
                           ptr    <= ptr_nxt;
                           state  <= ST_RX;
                        end
                     endcase
                  end
               end
               ST_TX: begin
                  if (scl_rise) begin
                     cnt <= cnt + 1'b1;
                  end else if (scl_fall) begin
                     if (byte_done) begin
                        sda_oe <= 1'b0;
                        state  <= ST_TXACK;
                     end else if (cnt != '0) begin
                        tx_sh  <= {tx_sh[BYTE_BITS-2:0], 1'b0};
                        sda_oe <= ~tx_sh[BYTE_BITS-2];
                     end
                  end
               end
               ST_TXACK: begin
                  if (scl_rise) begin
                     ptr   <= ptr_nxt;
                     state <= sda_s ? ST_SKIP : ST_TXLOAD;
                  end
               end
               ST_TXLOAD: begin
                  if (scl_fall) begin
                     tx_sh  <= rd_byte;
                     sda_oe <= ~rd_byte[BYTE_BITS-1];
                     cnt    <= '0;
                     state  <= ST_TX;
                  end
               end
               default: begin
                  sda_oe <= 1'b0;
               end
            endcase
         end
      end
   end
endmodule

// File: rtl/quad_wiper_i2c_target.sv
module quad_wiper_i2c_target #(
   parameter int NCH         = 4,
   parameter int WIPER_W     = 8,
   parameter int RESET_VAL   = 128,
   parameter int SYNC_STAGES = 2,
   localparam int PW         = (NCH > 1) ? $clog2(NCH) : 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   scl_i,
   input  logic                   sda_i,
   output logic                   sda_oe,
   input  logic [2:0]             addr_sel,
   output logic [NCH*WIPER_W-1:0] wipers
);
   if (NCH < 1 || NCH > 256) begin : g_bad_nch
      $error("NCH must lie in 1..256");
   end
   if (WIPER_W < 1 || WIPER_W > 8) begin : g_bad_ww
      $error("WIPER_W must lie in 1..8");
   end
   if (RESET_VAL < 0 || RESET_VAL >= (1 << WIPER_W)) begin : g_bad_rst
      $error("RESET_VAL does not fit in WIPER_W bits");
   end

   logic               sda_s;
   logic               scl_rise;
   logic               scl_fall;
   logic               start_det;
   logic               stop_det;
   logic               wr_en;
   logic [PW-1:0]      ptr;
   logic [WIPER_W-1:0] wr_data;
   logic [WIPER_W-1:0] rd_data;

   qw_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl_i),
      .sda_i     (sda_i),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det)
   );

   qw_proto #(.NCH(NCH), .WW(WIPER_W)) u_proto (
      .clk       (clk),
      .rst_n     (rst_n),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det),
      .addr_sel  (addr_sel),
      .rd_data   (rd_data),
      .wr_en     (wr_en),
      .ptr       (ptr),
      .wr_data   (wr_data),
      .sda_oe    (sda_oe)
   );

   qw_wiper_bank #(.NCH(NCH), .WW(WIPER_W), .RESET_VAL(RESET_VAL)) u_bank (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .idx     (ptr),
      .wr_data (wr_data),
      .rd_data (rd_data),
      .wipers  (wipers)
   );
endmodule

// File: rtl/qw_checker.sv
module qw_checker #(
   parameter int NCH = 4,
   parameter int WW  = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              scl_i,
   input logic              sda_i,
   input logic              sda_oe,
   input logic [NCH*WW-1:0] wipers
);
   logic [NCH*WW-1:0] wip_q;
   logic              oe_q;
   logic              scl_q;
   logic              sda_q;
   logic [NCH-1:0]    chg;

   always_ff @(posedge clk) begin
      wip_q <= wipers;
      oe_q  <= sda_oe;
      scl_q <= scl_i;
      sda_q <= sda_i;
   end

   for (genvar i = 0; i < NCH; i++) begin : g_chg
      assign chg[i] = (wipers[i*WW +: WW] != wip_q[i*WW +: WW]);
   end

   // R8
   sda_drive_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sda_oe != oe_q) |-> !scl_i);

   // R5
   single_channel_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(chg));

   // R4
   commit_in_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (chg != '0) |-> sda_oe);

   // R7
   release_at_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (scl_i && scl_q && sda_i && !sda_q) |-> !sda_oe);
endmodule

bind quad_wiper_i2c_target qw_checker #(.NCH(NCH), .WW(WIPER_W)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .scl_i  (scl_i),
   .sda_i  (sda_i),
   .sda_oe (sda_oe),
   .wipers (wipers)
);

// File: tb/quad_wiper_i2c_target_test.sv
`timescale 1ns/1ps
module quad_wiper_i2c_target_test;
   localparam int Q = 40;
   localparam int H = 80;
   localparam logic [2:0] PINS = 3'b101;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mscl = 1'b1;
   logic        msda = 1'b1;
   logic        sda_oe;
   logic        sda_line;
   logic [31:0] wipers;
   int          checks = 0;
   int          fails = 0;
   logic [7:0]  expw [4];
   logic [7:0]  dbuf [8];

   always #2.5 clk = ~clk;
   assign sda_line = msda & ~sda_oe;

   quad_wiper_i2c_target uut (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_i    (mscl),
      .sda_i    (sda_line),
      .sda_oe   (sda_oe),
      .addr_sel (PINS),
      .wipers   (wipers)
   );

   function automatic logic [7:0] id_byte(input logic rd);
      return {4'b1010, PINS, rd};
   endfunction

   function automatic int nxt(input int a);
      return (a + 1) % 4;
   endfunction

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic chk_all(input string tag);
      for (int i = 0; i < 4; i++) chk(tag, int'(wipers[i*8 +: 8]), int'(expw[i]));
   endtask

   task automatic bus_start();
      msda = 1'b1; #Q;
      mscl = 1'b1; #Q;
      msda = 1'b0; #Q;
      mscl = 1'b0; #Q;
   endtask

   task automatic bus_stop();
      msda = 1'b0; #Q;
      mscl = 1'b1; #Q;
      msda = 1'b1; #Q;
   endtask

   task automatic bit_out(input logic b);
      msda = b; #Q;
      mscl = 1'b1; #H;
      mscl = 1'b0; #Q;
   endtask

   task automatic send_byte(input logic [7:0] b, output logic ack);
      for (int i = 7; i >= 0; i--) bit_out(b[i]);
      msda = 1'b1; #Q;
      mscl = 1'b1; #(H/2);
      ack = ~sda_line; #(H/2);
      mscl = 1'b0; #Q;
   endtask

   task automatic recv_byte(input logic nack, output logic [7:0] b);
      logic s0;
      msda = 1'b1;
      for (int i = 0; i < 8; i++) begin
         #Q; mscl = 1'b1; #(H/4);
         s0 = sda_line; #(H/4);
         b = {b[6:0], sda_line}; #(H/2);
         // R8: data from target must hold through the high phase
         chk("R8", int'(sda_line), int'(s0));
         mscl = 1'b0;
      end
      #Q; msda = nack; #Q;
      mscl = 1'b1; #H;
      mscl = 1'b0; #Q;
   endtask

   task automatic do_write(input int a, input int n);
      logic ack;
      bus_start();
      send_byte(id_byte(1'b0), ack); chk("R2", int'(ack), 1);
      send_byte(8'(a), ack);         chk("R3", int'(ack), 1);
      for (int k = 0; k < n; k++) begin
         send_byte(dbuf[k], ack);
         chk("R5", int'(ack), 1);
         expw[(a + k) % 4] = dbuf[k];
         // R4: committed after ninth clock, before STOP
         chk("R4", int'(wipers[((a + k) % 4)*8 +: 8]), int'(dbuf[k]));
      end
      bus_stop();
      chk_all("R5");
   endtask

   task automatic do_read(input int a, input int n);
      logic ack;
      logic [7:0] b;
      int p;
      bus_start();
      send_byte(id_byte(1'b0), ack); chk("R2", int'(ack), 1);
      send_byte(8'(a), ack);         chk("R3", int'(ack), 1);
      bus_start();
      send_byte(id_byte(1'b1), ack); chk("R6", int'(ack), 1);
      p = a;
      for (int k = 0; k < n; k++) begin
         recv_byte(k == n - 1, b);
         chk("R6", int'(b), int'(expw[p]));
         p = nxt(p);
      end
      chk("R7", int'(sda_oe), 0);
      bus_stop();
      chk("R7", int'(sda_oe), 0);
   endtask

   task automatic bad_id(input logic [7:0] idb);
      logic ack;
      bus_start();
      send_byte(idb, ack); chk("R2", int'(ack), 0);
      send_byte(8'h01, ack);
      send_byte(8'h3C, ack); chk("R2", int'(ack), 0);
      bus_stop();
      chk_all("R2");
   endtask

   task automatic bad_addr(input logic [7:0] a);
      logic ack;
      bus_start();
      send_byte(id_byte(1'b0), ack); chk("R2", int'(ack), 1);
      send_byte(a, ack);             chk("R3", int'(ack), 0);
      send_byte(8'hA5, ack);
      bus_stop();
      chk_all("R3");
   endtask

   task automatic abort_write(input int a, input logic use_start);
      logic ack;
      bus_start();
      send_byte(id_byte(1'b0), ack);
      send_byte(8'(a), ack);
      for (int i = 0; i < 5; i++) bit_out(1'b0);
      if (use_start) bus_start();
      bus_stop();
      // R9: no wiper written by the broken byte
      chk_all("R9");
   endtask

   initial begin
      #(200000 * 5);
      fails++;
      $display("FAIL watchdog R1-all actual=timeout expected=done");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      for (int i = 0; i < 4; i++) expw[i] = 8'd128;
      #50;
      rst_n = 1'b1;
      #50;
      // R1: reset state
      chk_all("R1");
      chk("R1", int'(sda_oe), 0);

      // Directed corner cases
      dbuf[0] = 8'h11; dbuf[1] = 8'h22; dbuf[2] = 8'h33; dbuf[3] = 8'h44; dbuf[4] = 8'h55;
      do_write(3, 5);
      do_read(3, 3);
      do_read(0, 4);
      bad_id({4'b1010, 3'b100, 1'b0});
      bad_id({4'b1011, PINS, 1'b0});
      bad_addr(8'h04);
      bad_addr(8'hFF);
      abort_write(1, 1'b0);
      abort_write(2, 1'b1);
      dbuf[0] = 8'h00; dbuf[1] = 8'hFF;
      do_write(2, 2);
      do_read(2, 2);

      // Constrained random mix
      for (int t = 0; t < 24; t++) begin
         int kind;
         int a;
         int n;
         kind = int'($urandom % 5);
         a    = int'($urandom % 4);
         n    = 1 + int'($urandom % 5);
         case (kind)
            0, 1: begin
               for (int k = 0; k < n; k++) dbuf[k] = 8'($urandom);
               do_write(a, n);
            end
            2: do_read(a, n);
            3: bad_addr(8'(4 + ($urandom % 252)));
            default: bad_id({4'b1010, PINS ^ 3'(1 + ($urandom % 7)), 1'($urandom)});
         endcase
      end
      do_read(0, 4);

      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule